// File: doc/BRIEF.md
# Power-Loss Recovery Wake Controller

This block runs on an always-on clock and follows the platform through a full loss of main and standby power. It watches the main power-good input and the active-low resume-well reset input, and sets sticky failure flags when either drops. When the resume-well reset falls, it records the sleep state the platform was in. When that reset is released, it decides which state the platform enters next. The decision comes from one stay-off policy bit together with the recorded state.

The block holds a status register and a configuration register. Status bits are write-one-to-clear. The configuration register models battery-backed storage, so only the block reset `rst` clears it, which stands for the battery-well reset. During an outage, status bits that live in the resume well are forced to zero. The failure flags and all configuration bits survive.

Only a small set of sources may wake the platform once power is back: the power button, ring indicate, the RTC alarm and the PCI Express wake pin. Each wake is reported as a one-cycle pulse on a per-source vector. PME events only log status and never raise a wake.

Top module: `pwr_loss_wake_ctl`

## Requirements
- R1: State encoding is S0=0, S1=1, S3=3, S4=4, S5=5. When the stay-off bit (config bit 0) is 0, every power return decides S0. When it is 1 and the recorded state was S0, S1 or S3, the decision is S5.
- R2: With the stay-off bit at 1 and S4 recorded at failure, the decision is S4.
- R3: With the stay-off bit at 1 and S5 recorded at failure, the decision is S5.
- R4: `decide_valid_o` pulses exactly once per outage, one cycle after the synchronized release of the resume-well reset. `next_state_o` holds the decision from that cycle on.
- R5: While the synchronized main power-good input is low, status bit 0 (power-good failure) is set, and it stays set after power-good returns.
- R6: While the synchronized resume-well reset is low, status bit 1 (power failure) is set, and it stays set after release.
- R7: During an outage, status bits 2 (button), 4 (RTC alarm), 5 (PME) and 6 (PCI Express PME message) read 0. Config bits (0 stay-off, 1 ring enable, 2 RTC enable, 3 PME enable) are kept through an outage and cleared only by `rst`.
- R8: Writing address 0 clears each status bit whose data bit is 1. A hardware set in the same cycle wins over the clear. Address 1 writes the config register.
- R9: A synchronized falling edge of the power button sets status bit 2 and raises wake source bit 0. The button needs no enable.
- R10: With ring enable set, ring indicate going low during an outage sets status bit 3 and raises wake source bit 1 when power returns. With ring enable clear, neither happens.
- R11: An RTC alarm pulse sets status bit 4. It raises wake source bit 2 only when RTC enable is set.
- R12: A PCI Express wake falling edge raises wake source bit 3 when the current state is S1, S3, S4 or S5, and it sets no status bit. In S0 it raises nothing. PME events set status bit 5 and PME messages set status bit 6, and neither raises a wake.
- R13: No wake source fires while the resume-well reset is asserted.
- R14: After `rst`, status and config are 0, `next_state_o` is S5, and `decide_valid_o` and all wake outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset (battery-well reset) |
| main_pgood_i | input | 1 | Main power-good, asynchronous |
| rsm_rst_n_i | input | 1 | Resume-well reset, active low, asynchronous |
| pwrbtn_n_i | input | 1 | Power button, active low, asynchronous |
| ring_n_i | input | 1 | Ring indicate, active low, asynchronous |
| pcie_wake_n_i | input | 1 | PCI Express wake pin, active low, asynchronous |
| rtc_alarm_i | input | 1 | RTC alarm pulse, clock domain |
| pme_evt_i | input | 1 | PME event pulse, clock domain |
| pcie_pme_msg_i | input | 1 | PCI Express PME message pulse, clock domain |
| cur_state_i | input | 3 | Current sleep state encoding |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 status, 1 config |
| wr_data_i | input | 8 | Register write data |
| status_o | output | 8 | Status register |
| config_o | output | 4 | Config register |
| decide_valid_o | output | 1 | Decision pulse |
| next_state_o | output | 3 | State to enter on power return |
| wake_o | output | 1 | Any wake source fired |
| wake_src_o | output | 4 | Per-source wake pulse: button, ring, RTC, PCI Express |

## Verification
The bench runs the full outage sequence for each recorded state under both policy values. A design that ignores the recorded state would leave S4 on a stay-off return, and one that reads the policy the wrong way round would boot from a stay-off setting. It holds power-good low while software clears the flag, which exposes a design where the clear beats the hardware set. It drops ring indicate only while power is out, with ring enable both set and clear; a design that drops the condition during the outage, or ignores the enable, would log or miss that wake. It also checks which bits an outage may clear: a design that cleared battery-backed enables, kept resume-well status, or let a PME or S0 wake pin raise a wake shows up in the status, config or wake counts.

// File: rtl/plw_pkg.sv
package plw_pkg;

    typedef enum logic [2:0] {
        SLP_S0 = 3'd0,
        SLP_S1 = 3'd1,
        SLP_S3 = 3'd3,
        SLP_S4 = 3'd4,
        SLP_S5 = 3'd5
    } slp_e;

    localparam int STS_W = 8;
    localparam int CFG_W = 4;
    localparam int NWAKE = 4;

    // status bit positions
    localparam int B_PGOOD = 0;
    localparam int B_PWR   = 1;
    localparam int B_BTN   = 2;
    localparam int B_RING  = 3;
    localparam int B_RTC   = 4;
    localparam int B_PME   = 5;
    localparam int B_PCIE  = 6;

    // config bit positions
    localparam int C_OFF  = 0;
    localparam int C_RING = 1;
    localparam int C_RTC  = 2;
    localparam int C_PME  = 3;

    // wake source positions
    localparam int W_BTN  = 0;
    localparam int W_RING = 1;
    localparam int W_RTC  = 2;
    localparam int W_PCIE = 3;

    localparam logic [STS_W-1:0] STS_MASK   = STS_W'((1 << (B_PCIE + 1)) - 1);
    localparam logic [STS_W-1:0] OUTAGE_CLR =
        STS_W'((1 << B_BTN) | (1 << B_RTC) | (1 << B_PME) | (1 << B_PCIE));

    typedef struct packed {
        logic outage;
        logic rsm_fall;
        logic rsm_rise;
        logic pgood_low;
        logic btn_fall;
        logic ring_low;
        logic ring_fall;
        logic pcie_fall;
    } evt_t;

    function automatic logic [2:0] recover_state(input logic stay_off, input logic [2:0] saved);
        if (!stay_off)            return SLP_S0;
        else if (saved == SLP_S4) return SLP_S4;
        else                      return SLP_S5;
    endfunction

    function automatic logic wake_capable(input logic [2:0] st);
        return (st == SLP_S1) || (st == SLP_S3) || (st == SLP_S4) || (st == SLP_S5);
    endfunction

endpackage

// File: rtl/plw_sync.sv
module plw_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] fall_o,
    output logic [W-1:0] rise_o
);
    logic [STAGES-1:0][W-1:0] chain_q;
    logic [W-1:0]             prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
    assign fall_o = prev_q & ~sync_o;
    assign rise_o = ~prev_q & sync_o;
endmodule

// File: rtl/plw_regs.sv
module plw_regs
    import plw_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int DATA_W   = 8,
    parameter int ADDR_STS = 0,
    parameter int ADDR_CFG = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [STS_W-1:0]  hw_set_i,
    input  logic              outage_i,
    output logic [STS_W-1:0]  sts_o,
    output logic [CFG_W-1:0]  cfg_o
);
    logic [STS_W-1:0] w1c;
    logic [STS_W-1:0] sts_d;

    always_comb begin
        w1c = '0;
        if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_STS)) w1c = wr_data_i[STS_W-1:0];
        // hardware set is applied after the clear, so it wins
        sts_d = ((sts_o & ~w1c) | hw_set_i) & STS_MASK;
        if (outage_i) sts_d = sts_d & ~OUTAGE_CLR;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_o <= '0;
            cfg_o <= '0;
        end else begin
            sts_o <= sts_d;
            if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_CFG)) cfg_o <= wr_data_i[CFG_W-1:0];
        end
    end
endmodule

// File: rtl/plw_wake.sv
module plw_wake
    import plw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evt_t             evt_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             rtc_alarm_i,
    input  logic [2:0]       cur_state_i,
    output logic             btn_set_o,
    output logic             ring_set_o,
    output logic             rtc_set_o,
    output logic [NWAKE-1:0] wake_src_o
);
    logic             ring_seen_q;
    logic [NWAKE-1:0] src_d;

    always_comb begin
        btn_set_o  = evt_i.btn_fall & ~evt_i.outage;
        ring_set_o = cfg_i[C_RING] &
                     ((evt_i.ring_fall & ~evt_i.outage) | (evt_i.rsm_rise & ring_seen_q));
        rtc_set_o  = rtc_alarm_i & ~evt_i.outage;
        src_d         = '0;
        src_d[W_BTN]  = btn_set_o;
        src_d[W_RING] = ring_set_o;
        src_d[W_RTC]  = rtc_set_o & cfg_i[C_RTC];
        src_d[W_PCIE] = evt_i.pcie_fall & ~evt_i.outage & wake_capable(cur_state_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_seen_q <= 1'b0;
            wake_src_o  <= '0;
        end else begin
            wake_src_o <= src_d;
            if (evt_i.rsm_rise)
                ring_seen_q <= 1'b0;
            else if (evt_i.outage && cfg_i[C_RING] && evt_i.ring_low)
                ring_seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/plw_recovery.sv
module plw_recovery
    import plw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rsm_fall_i,
    input  logic       rsm_rise_i,
    input  logic [2:0] cur_state_i,
    input  logic       stay_off_i,
    output logic       decide_o,
    output logic [2:0] next_state_o,
    output logic [2:0] saved_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            saved_o      <= SLP_S5;
            next_state_o <= SLP_S5;
            decide_o     <= 1'b0;
        end else begin
            decide_o <= rsm_rise_i;
            if (rsm_fall_i) saved_o <= cur_state_i;
            if (rsm_rise_i) next_state_o <= recover_state(stay_off_i, saved_o);
        end
    end
endmodule

// File: rtl/pwr_loss_wake_ctl.sv
module pwr_loss_wake_ctl
    import plw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              main_pgood_i,
    input  logic              rsm_rst_n_i,
    input  logic              pwrbtn_n_i,
    input  logic              ring_n_i,
    input  logic              pcie_wake_n_i,
    input  logic              rtc_alarm_i,
    input  logic              pme_evt_i,
    input  logic              pcie_pme_msg_i,
    input  logic [2:0]        cur_state_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [STS_W-1:0]  status_o,
    output logic [CFG_W-1:0]  config_o,
    output logic              decide_valid_o,
    output logic [2:0]        next_state_o,
    output logic              wake_o,
    output logic [NWAKE-1:0]  wake_src_o
);
    localparam int I_PGOOD = 0;
    localparam int I_RSM   = 1;
    localparam int I_BTN   = 2;
    localparam int I_RING  = 3;
    localparam int I_PCIE  = 4;
    localparam int NSYNC   = 5;

    logic [NSYNC-1:0] raw, sync_v, fall_v, rise_v;
    logic             rsm_s, pgood_s;
    logic [2:0]       saved_state;
    evt_t             evt;
    logic             btn_set, ring_set, rtc_set;
    logic [STS_W-1:0] hw_set;

    assign raw = {pcie_wake_n_i, ring_n_i, pwrbtn_n_i, rsm_rst_n_i, main_pgood_i};

    plw_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL({NSYNC{1'b1}})) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_i    (raw),
        .sync_o (sync_v),
        .fall_o (fall_v),
        .rise_o (rise_v)
    );

    assign rsm_s   = sync_v[I_RSM];
    assign pgood_s = sync_v[I_PGOOD];

    always_comb begin
        evt.outage    = ~rsm_s;
        evt.rsm_fall  = fall_v[I_RSM];
        evt.rsm_rise  = rise_v[I_RSM];
        evt.pgood_low = ~pgood_s;
        evt.btn_fall  = fall_v[I_BTN];
        evt.ring_low  = ~sync_v[I_RING];
        evt.ring_fall = fall_v[I_RING];
        evt.pcie_fall = fall_v[I_PCIE];
    end

    plw_wake u_wake (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .cfg_i       (config_o),
        .rtc_alarm_i (rtc_alarm_i),
        .cur_state_i (cur_state_i),
        .btn_set_o   (btn_set),
        .ring_set_o  (ring_set),
        .rtc_set_o   (rtc_set),
        .wake_src_o  (wake_src_o)
    );

    always_comb begin
        hw_set          = '0;
        hw_set[B_PGOOD] = evt.pgood_low;
        hw_set[B_PWR]   = evt.outage;
        hw_set[B_BTN]   = btn_set;
        hw_set[B_RING]  = ring_set;
        hw_set[B_RTC]   = rtc_set;
        hw_set[B_PME]   = pme_evt_i & ~evt.outage;
        hw_set[B_PCIE]  = pcie_pme_msg_i & ~evt.outage;
    end

    plw_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .hw_set_i  (hw_set),
        .outage_i  (evt.outage),
        .sts_o     (status_o),
        .cfg_o     (config_o)
    );

    plw_recovery u_rec (
        .clk          (clk),
        .rst          (rst),
        .rsm_fall_i   (evt.rsm_fall),
        .rsm_rise_i   (evt.rsm_rise),
        .cur_state_i  (cur_state_i),
        .stay_off_i   (config_o[C_OFF]),
        .decide_o     (decide_valid_o),
        .next_state_o (next_state_o),
        .saved_o      (saved_state)
    );

    assign wake_o = |wake_src_o;
endmodule

// File: rtl/plw_chk.sv
module plw_chk
    import plw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rsm_s,
    input logic             pgood_s,
    input logic [2:0]       cur_state,
    input logic [2:0]       saved_state,
    input logic [2:0]       next_state,
    input logic [CFG_W-1:0] cfg,
    input logic [STS_W-1:0] status,
    input logic             decide_v,
    input logic             wake,
    input logic [NWAKE-1:0] wake_src
);
    // R4
    decide_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        decide_v |-> ($past(rsm_s) && !$past(rsm_s, 2)));

    // R1
    policy_boot_chk: assert property (@(posedge clk) disable iff (rst)
        (decide_v && !$past(cfg[C_OFF])) |-> next_state == SLP_S0);

    // R2
    keep_s4_chk: assert property (@(posedge clk) disable iff (rst)
        (decide_v && $past(cfg[C_OFF]) && saved_state == SLP_S4) |-> next_state == SLP_S4);

    // R3
    stay_off_chk: assert property (@(posedge clk) disable iff (rst)
        (decide_v && $past(cfg[C_OFF]) && saved_state != SLP_S4) |-> next_state == SLP_S5);

    // R5
    pgood_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(pgood_s) |-> status[B_PGOOD]);

    // R6
    pwr_fail_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rsm_s) |-> status[B_PWR]);

    // R7
    outage_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rsm_s) |-> (status & OUTAGE_CLR) == '0);

    // R13
    quiet_outage_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> $past(rsm_s));

    // R12
    pcie_state_chk: assert property (@(posedge clk) disable iff (rst)
        wake_src[W_PCIE] |-> $past(cur_state) != SLP_S0);

    // R9
    btn_log_chk: assert property (@(posedge clk) disable iff (rst)
        wake_src[W_BTN] |-> status[B_BTN]);
endmodule

bind pwr_loss_wake_ctl plw_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rsm_s       (rsm_s),
    .pgood_s     (pgood_s),
    .cur_state   (cur_state_i),
    .saved_state (saved_state),
    .next_state  (next_state_o),
    .cfg         (config_o),
    .status      (status_o),
    .decide_v    (decide_valid_o),
    .wake        (wake_o),
    .wake_src    (wake_src_o)
);

// File: tb/pwr_loss_wake_ctl_tb.sv
module pwr_loss_wake_ctl_tb;
    import plw_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       main_pgood = 1'b1, rsm_n = 1'b1, btn_n = 1'b1, ring_n = 1'b1, pwake_n = 1'b1;
    logic       rtc_alarm = 1'b0, pme_evt = 1'b0, pcie_msg = 1'b0;
    logic [2:0] cur_state = 3'd0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] status;
    logic [3:0] cfg;
    logic       dec_v, wake;
    logic [2:0] next_state;
    logic [3:0] wake_src;

    int         checks = 0, errors = 0, n_dec = 0;
    int         n_wake [NWAKE];
    logic [2:0] last_next = 3'd7;

    always #10 clk = ~clk;

    pwr_loss_wake_ctl u_dut (
        .clk(clk), .rst(rst), .main_pgood_i(main_pgood), .rsm_rst_n_i(rsm_n),
        .pwrbtn_n_i(btn_n), .ring_n_i(ring_n), .pcie_wake_n_i(pwake_n),
        .rtc_alarm_i(rtc_alarm), .pme_evt_i(pme_evt), .pcie_pme_msg_i(pcie_msg),
        .cur_state_i(cur_state), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .status_o(status), .config_o(cfg), .decide_valid_o(dec_v),
        .next_state_o(next_state), .wake_o(wake), .wake_src_o(wake_src)
    );

    initial for (int i = 0; i < NWAKE; i++) n_wake[i] = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (dec_v) begin
                n_dec++;
                last_next = next_state;
            end
            for (int i = 0; i < NWAKE; i++) if (wake_src[i]) n_wake[i]++;
        end
    end

    function automatic int wake_total();
        int s = 0;
        for (int i = 0; i < NWAKE; i++) s += n_wake[i];
        return s;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
        cyc(3);
    endtask

    task automatic t_reset_state();
        chk("R14 status", status, 0);
        chk("R14 config", cfg, 0);
        chk("R14 next_state", next_state, SLP_S5);
        chk("R14 decide", dec_v, 0);
        chk("R14 wake", wake_src, 0);
    endtask

    task automatic t_outage(input string tag, input logic [2:0] st, input logic off,
                            input logic [2:0] expect_st);
        int d = n_dec;
        wr(2'd1, {4'h0, cfg[3:1], off});
        cur_state = st;
        @(negedge clk); rsm_n = 1'b0;
        cyc(6);
        chk("R6 power failure flag", status[B_PWR], 1);
        rsm_n = 1'b1;
        cyc(6);
        chk("R4 one decision", n_dec - d, 1);
        chk(tag, last_next, expect_st);
        chk("R6 flag kept", status[B_PWR], 1);
        wr(2'd0, 8'hFF);
    endtask

    task automatic t_pgood();
        @(negedge clk); main_pgood = 1'b0;
        cyc(6);
        chk("R5 pgood flag set", status[B_PGOOD], 1);
        wr(2'd0, 8'h01);
        chk("R8 hw set wins over clear", status[B_PGOOD], 1);
        main_pgood = 1'b1;
        cyc(6);
        chk("R5 pgood flag sticky", status[B_PGOOD], 1);
        wr(2'd0, 8'h01);
        chk("R8 w1c clears", status[B_PGOOD], 0);
    endtask

    task automatic t_button();
        int d = n_wake[W_BTN];
        @(negedge clk); btn_n = 1'b0;
        cyc(4); btn_n = 1'b1; cyc(4);
        chk("R9 button status", status[B_BTN], 1);
        chk("R9 button wake", n_wake[W_BTN] - d, 1);
        wr(2'd0, 8'h04);
        chk("R8 button cleared", status[B_BTN], 0);
    endtask

    task automatic t_ring(input logic en);
        int d = n_wake[W_RING];
        wr(2'd1, {4'h0, cfg[3:2], en, cfg[0]});
        @(negedge clk); rsm_n = 1'b0;
        cyc(5); ring_n = 1'b0;
        cyc(5); ring_n = 1'b1;
        cyc(5); rsm_n = 1'b1;
        cyc(6);
        chk(en ? "R10 ring status enabled" : "R10 ring status disabled", status[B_RING], int'(en));
        chk(en ? "R10 ring wake enabled" : "R10 ring wake disabled", n_wake[W_RING] - d, int'(en));
        wr(2'd0, 8'hFF);
    endtask

    task automatic t_rtc();
        int d = n_wake[W_RTC];
        int w;
        wr(2'd1, {4'h0, cfg[3], 1'b0, cfg[1:0]});
        pulse(rtc_alarm);
        chk("R11 rtc status", status[B_RTC], 1);
        chk("R11 rtc no wake when disabled", n_wake[W_RTC] - d, 0);
        wr(2'd0, 8'h10);
        wr(2'd1, {4'h0, cfg[3], 1'b1, cfg[1:0]});
        pulse(rtc_alarm);
        chk("R11 rtc wake when enabled", n_wake[W_RTC] - d, 1);
        // outage: resume-well status cleared, enable kept, no wake while out
        @(negedge clk); btn_n = 1'b0; cyc(4); btn_n = 1'b1; cyc(4);
        w = wake_total();
        @(negedge clk); rsm_n = 1'b0;
        cyc(6);
        chk("R7 rtc status cleared", status[B_RTC], 0);
        chk("R7 button status cleared", status[B_BTN], 0);
        btn_n = 1'b0; cyc(4); btn_n = 1'b1; cyc(4);
        rsm_n = 1'b1;
        cyc(6);
        chk("R7 rtc enable kept", cfg[C_RTC], 1);
        chk("R13 no wake during outage", wake_total() - w, 0);
        chk("R13 button status stays clear", status[B_BTN], 0);
        wr(2'd0, 8'hFF);
    endtask

    task automatic t_pcie();
        int d = n_wake[W_PCIE];
        int w;
        cur_state = SLP_S3;
        @(negedge clk); pwake_n = 1'b0; cyc(4); pwake_n = 1'b1; cyc(4);
        chk("R12 pcie wake from S3", n_wake[W_PCIE] - d, 1);
        chk("R12 pcie wake sets no status", status, 0);
        cur_state = SLP_S0;
        @(negedge clk); pwake_n = 1'b0; cyc(4); pwake_n = 1'b1; cyc(4);
        chk("R12 no pcie wake from S0", n_wake[W_PCIE] - d, 1);
        wr(2'd1, {4'h8 >> 0 | 4'h8, cfg} [3:0] | 4'h8);
        w = wake_total();
        pulse(pme_evt);
        pulse(pcie_msg);
        chk("R12 pme status", status[B_PME], 1);
        chk("R12 pcie message status", status[B_PCIE], 1);
        chk("R12 pme raises no wake", wake_total() - w, 0);
        @(negedge clk); rsm_n = 1'b0;
        cyc(6);
        chk("R7 pme status cleared", status[B_PME], 0);
        chk("R7 pcie message status cleared", status[B_PCIE], 0);
        rsm_n = 1'b1;
        cyc(6);
        chk("R7 pme enable kept", cfg[C_PME], 1);
        chk("R12 pme enable gives no wake", wake_total() - w, 0);
        @(negedge clk); rst = 1'b1;
        cyc(3); rst = 1'b0; cyc(1);
        chk("R7 config cleared by reset", cfg, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset_state();
        t_outage("R1 S3 stay-off gives S5", SLP_S3, 1'b1, SLP_S5);
        t_outage("R1 S1 stay-off gives S5", SLP_S1, 1'b1, SLP_S5);
        t_outage("R1 S0 boot gives S0",     SLP_S0, 1'b0, SLP_S0);
        t_outage("R2 S4 stay-off keeps S4", SLP_S4, 1'b1, SLP_S4);
        t_outage("R2 S4 boot gives S0",     SLP_S4, 1'b0, SLP_S0);
        t_outage("R3 S5 stay-off keeps S5", SLP_S5, 1'b1, SLP_S5);
        t_outage("R3 S5 boot gives S0",     SLP_S5, 1'b0, SLP_S0);
        t_pgood();
        t_button();
        t_ring(1'b1);
        t_ring(1'b0);
        t_rtc();
        t_pcie();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule